// File: doc/BRIEF.md
# PWM Phase Doubler Steering Controller

This block takes a single PWM stream and spreads it over two power phases, A and B. For each phase it drives three control levels: an upper-gate enable, a lower-gate enable, and an output-enable for the lower gate. When the output-enable is low, that lower gate floats (high impedance). The block also drives two control requests onto the shared PWM line. One asks for the line to be pulled high, which tells the upstream controller that this phase pair is switched off. The other asks for the line to be released to a floating level.

Starting and stopping are tied to PWM edges. A shutdown request takes effect only at a falling edge. A start request arms the block, and switching begins at the next rising edge. While the block is armed and PWM is low, both lower gates float. The exception is a phase whose node is reported above its high threshold: that phase gets its lower gate switched on.

In interleaved mode the pulses alternate between phases. In synchronous mode every pulse drives both phases. A current-balance unit can request a swap, which makes the phase that was not due fire instead. Each phase has a programmable dead time between its upper and lower enables.

Top module: `phase_doubler_ctrl`

## Requirements
- R1: After reset, with the enable input low, the block sits in its off state. In that state the pull-high request is 1, the release request is 0, both upper gates are 0, both lower gates are 0, and both lower output-enables are 1 (driven low).
- R2: When the enable input goes high, the pull-high request drops to 0 and the release request rises to 1, within a few cycles. No upper gate switches on until the first PWM rising edge after enable.
- R3: While armed and PWM is low, a phase's lower output-enable is 0 if its phase-high flag is 0. If the flag is 1, that phase's lower output-enable and lower gate are both 1.
- R4: With the mode input at 0 (interleaved), each PWM pulse turns on the upper gate of exactly one phase. Pulses alternate A, B, A, and so on, and the first pulse after each enable goes to A. Outside its pulse, a running phase keeps its lower gate on.
- R5: With the mode input at 1 (synchronous), each PWM pulse turns on both upper gates. Synchronous pulses do not advance the alternation order.
- R6: If the swap input is 1 when a rising PWM edge is detected, the phase not due fires instead. The phase due next is then the other one. The swap input is sampled only at rising edges, so it acts at most once per pulse.
- R7: When the enable input goes low while running, switching continues until the next PWM falling edge. At that edge the block enters the off state of R1, and no later pulse turns on an upper gate.
- R8: Within a phase, the upper and lower gates are never on at the same time. Before either gate turns on, both must have been off for at least DEAD_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Incoming PWM stream (asynchronous) |
| phase_en | input | 1 | Phase pair enable (asynchronous) |
| sync_mode | input | 1 | 0 = interleaved, 1 = synchronous (asynchronous) |
| swap_req | input | 1 | Request to fire the phase not due, from current balance |
| phase_hi_a | input | 1 | Phase A node above its high threshold |
| phase_hi_b | input | 1 | Phase B node above its high threshold |
| pwm_pull_high | output | 1 | Request to pull the shared PWM line high |
| pwm_release | output | 1 | Request to leave the shared PWM line floating |
| upper_a | output | 1 | Phase A upper-gate enable |
| lower_a | output | 1 | Phase A lower-gate enable |
| lower_oe_a | output | 1 | Phase A lower-gate output-enable (0 = high impedance) |
| upper_b | output | 1 | Phase B upper-gate enable |
| lower_b | output | 1 | Phase B lower-gate enable |
| lower_oe_b | output | 1 | Phase B lower-gate output-enable (0 = high impedance) |

## Verification
The bench builds the block with DEAD_CYC = 3 instead of the default 4. This confirms that the gap measured at the pins follows the parameter and is not a fixed constant, while keeping the switch-over latency well inside the pulse widths used (10 to 25 cycles high or low). With these short windows the bench can compare every pulse against its own firing-order model. It covers long runs of random swap requests and mode changes, shutdown requests arriving during a high phase and during a low phase, and the armed pre-start window with each phase-high flag.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [1:0] {
    PD_OFF   = 2'd0,
    PD_ARMED = 2'd1,
    PD_RUN   = 2'd2
  } pd_state_e;

  // Fire mask for one pulse: bit0 = phase A, bit1 = phase B.
  // nxt_b = 1 means phase B is due next.
  function automatic logic [1:0] pd_fire_mask(input logic nxt_b,
                                              input logic swap,
                                              input logic sync_m);
    logic pick_b;
    pick_b = nxt_b ^ swap;
    if (sync_m) return 2'b11;
    return pick_b ? 2'b10 : 2'b01;
  endfunction

  // Counter load value that yields a gap of dead_cyc cycles.
  function automatic int unsigned pd_gap_load(input int unsigned dead_cyc);
    return (dead_cyc > 0) ? dead_cyc - 1 : 0;
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] ff;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[0] <= '0;
          else        ff[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[s] <= '0;
          else        ff[s] <= ff[s-1];
        end
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwm_s,
  input  logic      en_s,
  input  logic      mode_s,
  input  logic      swap_req,
  output pd_state_e state,
  output logic [1:0] req_hi,
  output logic      pwm_rise,
  output logic      pwm_fall
);

  logic       pwm_d;
  logic       nxt_b;
  logic [1:0] fire;

  assign pwm_rise = pwm_s & ~pwm_d;
  assign pwm_fall = ~pwm_s & pwm_d;
  assign fire     = pd_fire_mask(nxt_b, swap_req, mode_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_d <= 1'b0;
    else        pwm_d <= pwm_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PD_OFF;
      req_hi <= 2'b00;
      nxt_b  <= 1'b0;
    end else begin
      unique case (state)
        PD_OFF: begin
          req_hi <= 2'b00;
          nxt_b  <= 1'b0;
          if (en_s) state <= PD_ARMED;
        end
        PD_ARMED: begin
          if (!en_s) begin
            state <= PD_OFF;
          end else if (pwm_rise) begin
            state  <= PD_RUN;
            req_hi <= fire;
            if (!mode_s) nxt_b <= fire[0];
          end
        end
        PD_RUN: begin
          if (pwm_rise) begin
            req_hi <= fire;
            if (!mode_s) nxt_b <= fire[0];
          end else if (pwm_fall) begin
            req_hi <= 2'b00;
            if (!en_s) state <= PD_OFF;
          end
        end
        default: state <= PD_OFF;
      endcase
    end
  end

endmodule

// File: rtl/pd_deadtime.sv
module pd_deadtime
  import pd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_on,
  output logic lo_on
);

  localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(pd_gap_load(DEAD_CYC));

  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_on   <= 1'b0;
      lo_on   <= 1'b0;
      gap_cnt <= '0;
    end else if (hi_on && !hi_req) begin
      hi_on   <= 1'b0;
      gap_cnt <= LOAD;
    end else if (lo_on && !lo_req) begin
      lo_on   <= 1'b0;
      gap_cnt <= LOAD;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end else if (hi_req && !lo_on && !hi_on) begin
      hi_on <= 1'b1;
    end else if (lo_req && !hi_on && !lo_on) begin
      lo_on <= 1'b1;
    end
  end

endmodule

// File: rtl/phase_doubler_ctrl.sv
module phase_doubler_ctrl
  import pd_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic phase_en,
  input  logic sync_mode,
  input  logic swap_req,
  input  logic phase_hi_a,
  input  logic phase_hi_b,
  output logic pwm_pull_high,
  output logic pwm_release,
  output logic upper_a,
  output logic lower_a,
  output logic lower_oe_a,
  output logic upper_b,
  output logic lower_b,
  output logic lower_oe_b
);

  localparam int NPH = 2;

  logic [2:0] sync_in;
  logic [2:0] sync_out;
  logic       pwm_s;
  logic       en_s;
  logic       mode_s;

  pd_state_e  state;
  logic [1:0] req_hi;
  logic       pwm_rise;
  logic       pwm_fall;
  logic       st_run;
  logic       st_armed;

  logic [NPH-1:0] ph_hi;
  logic [NPH-1:0] hi_req;
  logic [NPH-1:0] lo_req;
  logic [NPH-1:0] hi_on;
  logic [NPH-1:0] lo_on;
  logic [NPH-1:0] oe;

  assign sync_in = {sync_mode, phase_en, pwm_in};

  pd_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_in),
    .q     (sync_out)
  );

  assign pwm_s  = sync_out[0];
  assign en_s   = sync_out[1];
  assign mode_s = sync_out[2];

  pd_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_s    (pwm_s),
    .en_s     (en_s),
    .mode_s   (mode_s),
    .swap_req (swap_req),
    .state    (state),
    .req_hi   (req_hi),
    .pwm_rise (pwm_rise),
    .pwm_fall (pwm_fall)
  );

  assign st_run   = (state == PD_RUN);
  assign st_armed = (state == PD_ARMED);
  assign ph_hi    = {phase_hi_b, phase_hi_a};

  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_phase
      assign hi_req[p] = st_run & req_hi[p];
      assign lo_req[p] = st_run   ? ~req_hi[p] :
                         st_armed ? (ph_hi[p] & ~pwm_s) : 1'b0;

      pd_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_req (hi_req[p]),
        .lo_req (lo_req[p]),
        .hi_on  (hi_on[p]),
        .lo_on  (lo_on[p])
      );

      assign oe[p] = ~st_armed | lo_on[p];
    end
  endgenerate

  assign pwm_pull_high = (state == PD_OFF);
  assign pwm_release   = ~pwm_pull_high;

  assign upper_a    = hi_on[0];
  assign lower_a    = lo_on[0];
  assign lower_oe_a = oe[0];
  assign upper_b    = hi_on[1];
  assign lower_b    = lo_on[1];
  assign lower_oe_b = oe[1];

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       st_run,
  input logic       st_armed,
  input logic       pwm_s,
  input logic       pwm_rise,
  input logic       pwm_fall,
  input logic       en_s,
  input logic       mode_s,
  input logic [1:0] req_hi,
  input logic       phase_hi_a,
  input logic       phase_hi_b,
  input logic       pwm_pull_high,
  input logic       pwm_release,
  input logic       upper_a,
  input logic       lower_a,
  input logic       lower_oe_a,
  input logic       upper_b,
  input logic       lower_b,
  input logic       lower_oe_b
);

  localparam int GW = $clog2(DEAD_CYC + 2);
  localparam logic [GW-1:0] GMAX = GW'(DEAD_CYC + 1);

  logic [GW-1:0] gap_a, gap_b;
  logic          seen_a, seen_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_a  <= '0;
      gap_b  <= '0;
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      if (upper_a || lower_a) begin
        gap_a  <= '0;
        seen_a <= 1'b1;
      end else if (gap_a != GMAX) begin
        gap_a <= gap_a + 1'b1;
      end
      if (upper_b || lower_b) begin
        gap_b  <= '0;
        seen_b <= 1'b1;
      end else if (gap_b != GMAX) begin
        gap_b <= gap_b + 1'b1;
      end
    end
  end

  assert_line_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_pull_high && pwm_release));

  assert_upper_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_run) |-> (!upper_a && !upper_b));

  assert_prestart_float_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && $past(st_armed) && !$past(phase_hi_a) && !$past(pwm_s)) |-> !lower_oe_a);

  assert_prestart_float_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_armed && $past(st_armed) && !$past(phase_hi_b) && !$past(pwm_s)) |-> !lower_oe_b);

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && pwm_rise && !mode_s) |=> $onehot(req_hi));

  assert_both_phases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_run || st_armed) && en_s && pwm_rise && mode_s) |=> (req_hi == 2'b11));

  assert_stop_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_run && pwm_fall && !en_s) |=> pwm_pull_high);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upper_a && lower_a) && !(upper_b && lower_b));

  assert_gap_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_a && ($rose(upper_a) || $rose(lower_a))) |-> (gap_a >= GW'(DEAD_CYC)));

  assert_gap_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_b && ($rose(upper_b) || $rose(lower_b))) |-> (gap_b >= GW'(DEAD_CYC)));

endmodule

bind phase_doubler_ctrl pd_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_run        (st_run),
  .st_armed      (st_armed),
  .pwm_s         (pwm_s),
  .pwm_rise      (pwm_rise),
  .pwm_fall      (pwm_fall),
  .en_s          (en_s),
  .mode_s        (mode_s),
  .req_hi        (req_hi),
  .phase_hi_a    (phase_hi_a),
  .phase_hi_b    (phase_hi_b),
  .pwm_pull_high (pwm_pull_high),
  .pwm_release   (pwm_release),
  .upper_a       (upper_a),
  .lower_a       (lower_a),
  .lower_oe_a    (lower_oe_a),
  .upper_b       (upper_b),
  .lower_b       (lower_b),
  .lower_oe_b    (lower_oe_b)
);

// File: tb/phase_doubler_ctrl_tb.sv
module phase_doubler_ctrl_tb;

  localparam int DEAD = 3;
  localparam int WATCH_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, phase_en = 1'b0, sync_mode = 1'b0, swap_req = 1'b0;
  logic phase_hi_a = 1'b0, phase_hi_b = 1'b0;
  logic pwm_pull_high, pwm_release;
  logic upper_a, lower_a, lower_oe_a, upper_b, lower_b, lower_oe_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_nxt_b = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phase_doubler_ctrl #(.DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .phase_en(phase_en),
    .sync_mode(sync_mode), .swap_req(swap_req),
    .phase_hi_a(phase_hi_a), .phase_hi_b(phase_hi_b),
    .pwm_pull_high(pwm_pull_high), .pwm_release(pwm_release),
    .upper_a(upper_a), .lower_a(lower_a), .lower_oe_a(lower_oe_a),
    .upper_b(upper_b), .lower_b(lower_b), .lower_oe_b(lower_oe_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench restatement of the firing rule (R4, R5, R6): returns {B,A}.
  function automatic logic [1:0] want_fire(input bit sy, input bit sw);
    bit take_b;
    if (sy) return 2'b11;
    take_b = sw ? !exp_nxt_b : exp_nxt_b;
    exp_nxt_b = !take_b;
    return take_b ? 2'b10 : 2'b01;
  endfunction

  // Dead-time monitor on the pins (R8).
  int  off_a = 0, off_b = 0;
  bit  on_a_seen = 0, on_b_seen = 0;
  bit  pa_u = 0, pa_l = 0, pb_u = 0, pb_l = 0;
  int  viol_a = 0, viol_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((upper_a && lower_a) ||
          (on_a_seen && ((upper_a && !pa_u) || (lower_a && !pa_l)) && off_a < DEAD))
        viol_a++;
      if ((upper_b && lower_b) ||
          (on_b_seen && ((upper_b && !pb_u) || (lower_b && !pb_l)) && off_b < DEAD))
        viol_b++;
      if (upper_a || lower_a) begin off_a = 0; on_a_seen = 1; end else off_a++;
      if (upper_b || lower_b) begin off_b = 0; on_b_seen = 1; end else off_b++;
      pa_u = upper_a; pa_l = lower_a; pb_u = upper_b; pb_l = lower_b;
    end
  end

  // One PWM pulse; returns which upper gates switched on {B,A}.
  task automatic pulse(input int hi, input int lo, input bit sw, output logic [1:0] saw);
    saw = 2'b00;
    swap_req = sw;
    pwm_in = 1'b1;
    repeat (hi) begin
      @(negedge clk);
      saw |= {upper_b, upper_a};
    end
    swap_req = 1'b0;
    pwm_in = 1'b0;
    repeat (lo) begin
      @(negedge clk);
      saw |= {upper_b, upper_a};
    end
  endtask

  task automatic run_pulse(input int hi, input int lo, input bit sw, input string req);
    logic [1:0] saw, exp;
    exp = want_fire(sync_mode, sw);
    pulse(hi, lo, sw, saw);
    check(req, saw, exp);
  endtask

  initial begin
    repeat (WATCH_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] saw;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: off state after reset
    check("R1 pull_high", pwm_pull_high, 1);
    check("R1 release", pwm_release, 0);
    check("R1 uppers", {upper_b, upper_a}, 0);
    check("R1 lowers", {lower_b, lower_a}, 0);
    check("R1 lower_oe", {lower_oe_b, lower_oe_a}, 3);

    // R2: enable arms the block, no switching yet
    phase_en = 1'b1;
    exp_nxt_b = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 pull_high", pwm_pull_high, 0);
    check("R2 release", pwm_release, 1);
    check("R2 uppers idle", {upper_b, upper_a}, 0);

    // R3: pre-start floating lowers and phase-high override
    check("R3 both float", {lower_oe_b, lower_oe_a}, 0);
    phase_hi_a = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 A override oe", lower_oe_a, 1);
    check("R3 A override on", lower_a, 1);
    check("R3 B still float", lower_oe_b, 0);
    phase_hi_a = 1'b0;
    phase_hi_b = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 A back to float", lower_oe_a, 0);
    check("R3 B override", {lower_oe_b, lower_b}, 3);
    phase_hi_b = 1'b0;
    repeat (DEAD + 3) @(negedge clk);

    // R4: interleaved alternation starting at A
    for (int i = 0; i < 4; i++) run_pulse(12, 14, 1'b0, "R4 interleave");
    check("R4 lower on between pulses", {lower_b, lower_a}, 3);

    // R6: swap on demand, including back-to-back swaps
    run_pulse(12, 14, 1'b1, "R6 swap");
    run_pulse(12, 14, 1'b1, "R6 swap again");
    run_pulse(12, 14, 1'b0, "R6 after swap");

    // R5: synchronous mode fires both, order preserved
    sync_mode = 1'b1;
    repeat (4) @(negedge clk);
    run_pulse(12, 14, 1'b0, "R5 sync");
    run_pulse(12, 14, 1'b1, "R5 sync ignores swap");
    sync_mode = 1'b0;
    repeat (4) @(negedge clk);
    run_pulse(12, 14, 1'b0, "R5 order kept");

    // Random mix: R4, R5, R6
    for (int i = 0; i < 40; i++) begin
      int hi, lo;
      bit sw;
      hi = 10 + int'($urandom_range(15));
      lo = 10 + int'($urandom_range(15));
      sw = ($urandom_range(3) == 0);
      if ($urandom_range(5) == 0) begin
        sync_mode = !sync_mode;
        repeat (4) @(negedge clk);
      end
      run_pulse(hi, lo, sw, "R6 random order");
    end
    sync_mode = 1'b0;
    repeat (4) @(negedge clk);

    // R7: disable during high, shutdown waits for the falling edge
    swap_req = 1'b0;
    pwm_in = 1'b1;
    repeat (6) @(negedge clk);
    phase_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 still running in high", pwm_pull_high, 0);
    check("R7 upper held", upper_a | upper_b, 1);
    pwm_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 pull_high after fall", pwm_pull_high, 1);
    check("R7 release off", pwm_release, 0);
    check("R7 gates off", {upper_b, upper_a, lower_b, lower_a}, 0);
    pulse(12, 14, 1'b0, saw);
    check("R7 no pulse when off", saw, 0);

    // R7: disable during low, next pulse still fires, then off
    phase_en = 1'b1;
    exp_nxt_b = 1'b0;
    repeat (6) @(negedge clk);
    run_pulse(12, 14, 1'b0, "R4 restart at A");
    phase_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 waits in low", pwm_pull_high, 0);
    run_pulse(12, 14, 1'b0, "R7 last pulse fires");
    check("R7 off after last fall", pwm_pull_high, 1);
    pulse(12, 14, 1'b0, saw);
    check("R7 quiet after stop", saw, 0);

    // R8: dead time and exclusion seen at the pins
    check("R8 phase A gap", viol_a, 0);
    check("R8 phase B gap", viol_b, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule